// File: doc/BRIEF.md
# SPI status flags and slave-select control

This block holds the flag and control state of an SPI peripheral as seen by the CPU. A small register port (2-bit address, read and write strobes, 8-bit data) exposes a control register, a control/status register and a data register. A separate shift engine reports its events to the block: a byte exchange has finished, a received byte is ready, and a transmit is in progress. The block turns these events into four sticky flags and raises an interrupt. Each flag is cleared only by its own sequence of register accesses.

The block also picks the internal slave-select level. This level comes either from a synchronized external pin or from a software bit. The block drives the output-enable of the serial data pin and keeps the last received byte. It also produces the write enable that hands a CPU byte to the shift engine. Data-register writes are refused while an unacknowledged transfer-complete flag is pending.

Top module: `spi_flag_ctrl`

## Requirements
- R1: Transfer-complete (status bit 7) sets on `xfer_done`. It clears only when a status read (address 1) made while it is set is later followed by a read or write of the data register (address 2).
- R2: A data write while transfer-complete is set and no status read has yet been made during that setting produces no `dr_we` pulse. Otherwise a data write with `tx_busy` low gives a one-cycle `dr_we` pulse on the next cycle.
- R3: Write-collision (status bit 6) sets when the data register is written while `tx_busy` is 1. That write gives no `dr_we`. The flag clears by the same status-read-then-data-access sequence as R1.
- R4: Overrun (status bit 5) sets when `rx_valid` arrives while transfer-complete is already set. The new byte is then dropped and `rx_hold` keeps the older one. Any status read clears overrun.
- R5: Mode-fault (status bit 4) sets when `master_mode` is 1 and the internal slave-select is 0. It clears only when a status access (read or write) made while it is set is followed by a control-register write (address 0).
- R6: `irq` is 1 one cycle after control bit 7 (interrupt enable) is 1 and any of transfer-complete, overrun or mode-fault is set. It is 0 otherwise.
- R7: A status read returns {bit 7 to 4: flags, bit 3: 0, bit 2: output-disable, bit 1: select-source, bit 0: software select level}. Writes to the status register change only bits 2 to 0.
- R8: `sdo_oe` is 1 only when control bit 6 (peripheral enable) is 1 and status bit 2 (output-disable) is 0.
- R9: With status bit 1 set to 1, `ss_int` follows status bit 0 and `ss_pin` has no effect. With status bit 1 set to 0, `ss_int` follows `ss_pin` after a two-flop synchronizer and one output register.
- R10: A flag-setting event in the same cycle as that flag's clearing access leaves the flag set. It also discards the status-read marker, so a new status read is needed before the flag can clear.
- R11: After reset all flags, markers, registers, `irq`, `dr_we` and `rx_hold` are 0. `ss_int` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd` |
| xfer_done | input | 1 | Shift engine: byte exchange finished |
| rx_valid | input | 1 | Shift engine: received byte ready on `rx_byte` |
| rx_byte | input | 8 | Shift engine: received byte |
| tx_busy | input | 1 | Shift engine: transmit in progress |
| master_mode | input | 1 | Peripheral is operating as master |
| ss_pin | input | 1 | External slave-select pin, asynchronous |
| irq | output | 1 | Interrupt request |
| ss_int | output | 1 | Internal slave-select level (0 = selected) |
| sdo_oe | output | 1 | Serial data output enable |
| rx_hold | output | 8 | Received-data holding register |
| dr_we | output | 1 | Accepted data-register write, to the shift engine |

## Verification
The in-RTL assertions watch properties that hold on every cycle. A flag rises only after its set event, and it falls only after its own clearing access. A set event always leaves its flag set. The interrupt tracks the enable and the flags one cycle later. A blocked or colliding write never produces `dr_we`. `rx_hold` does not move on an overrun. The bench's scenarios are needed for the multi-access ordering. They show that a data access without an earlier status read leaves transfer-complete set, and that a control write alone does not clear mode-fault. They also cover the slave-select source and output-enable combinations walked from a table, and the pin synchronizer latency.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_DATA = 2'd2;
  // flag slots, index into the flag vector
  localparam int unsigned NFLAG = 4;
  localparam int unsigned F_DONE = 0;
  localparam int unsigned F_WCOL = 1;
  localparam int unsigned F_OVR  = 2;
  localparam int unsigned F_MODF = 3;
  // control register bits
  localparam int unsigned C_IE = 7;
  localparam int unsigned C_PE = 6;
endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
  parameter bit TWO_STEP = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic arm,
  input  logic fire,
  output logic flag,
  output logic mark
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      mark <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
      mark <= 1'b0;
    end else if (TWO_STEP) begin
      if (arm && flag) mark <= 1'b1;
      if (fire && mark) begin
        flag <= 1'b0;
        mark <= 1'b0;
      end
    end else if (arm) begin
      flag <= 1'b0;
    end
  end

  // R10: set event wins over a clearing access
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  // R1: a flag only rises after its event
  a_r1_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(set));
  // R1/R4: a flag only falls after its own clearing access
  a_r1_fall_needs_seq: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> (TWO_STEP ? ($past(fire) && $past(mark)) : $past(arm)));
endmodule

// File: rtl/spi_ss_select.sv
module spi_ss_select #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic sw_sel,
  input  logic sw_lvl,
  output logic ss_lvl
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      ss_lvl <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      ss_lvl <= sw_sel ? sw_lvl : sync_q[STAGES-1];
    end
  end

  // R9: software source overrides the pin
  a_r9_sw_source: assert property (@(posedge clk) disable iff (rst)
    $past(sw_sel) && !$past(rst) |-> ss_lvl == $past(sw_lvl));
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          xfer_done,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_busy,
  input  logic          master_mode,
  input  logic          ss_pin,
  output logic          irq,
  output logic          ss_int,
  output logic          sdo_oe,
  output logic [DW-1:0] rx_hold,
  output logic          dr_we
);
  localparam bit [NFLAG-1:0] TWO_STEP_MAP = 4'b1011;

  logic [DW-1:0]    ctrl_q;
  logic             sod_q, ssm_q, ssi_q;
  logic [NFLAG-1:0] f_set, f_arm, f_fire, f_flag, f_mark;
  logic stat_rd, stat_acc, ctrl_wr, data_wr, data_acc, wr_block;

  assign stat_rd  = rd && addr == A_STAT;
  assign stat_acc = (rd || wr) && addr == A_STAT;
  assign ctrl_wr  = wr && addr == A_CTRL;
  assign data_wr  = wr && addr == A_DATA;
  assign data_acc = (rd || wr) && addr == A_DATA;
  assign wr_block = f_flag[F_DONE] && !f_mark[F_DONE];

  always_comb begin
    f_set[F_DONE]  = xfer_done;
    f_arm[F_DONE]  = stat_rd;
    f_fire[F_DONE] = data_acc;
    f_set[F_WCOL]  = data_wr && tx_busy;
    f_arm[F_WCOL]  = stat_rd;
    f_fire[F_WCOL] = data_acc;
    f_set[F_OVR]   = rx_valid && f_flag[F_DONE];
    f_arm[F_OVR]   = stat_rd;
    f_fire[F_OVR]  = 1'b0;
    f_set[F_MODF]  = master_mode && !ss_int;
    f_arm[F_MODF]  = stat_acc;
    f_fire[F_MODF] = ctrl_wr;
  end

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      spi_flag_cell #(.TWO_STEP(TWO_STEP_MAP[i])) u_cell (
        .clk(clk), .rst(rst), .set(f_set[i]), .arm(f_arm[i]),
        .fire(f_fire[i]), .flag(f_flag[i]), .mark(f_mark[i]));
    end
  endgenerate

  spi_ss_select #(.STAGES(SYNC_STAGES)) u_ss (
    .clk(clk), .rst(rst), .pin(ss_pin), .sw_sel(ssm_q), .sw_lvl(ssi_q),
    .ss_lvl(ss_int));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      sod_q   <= 1'b0;
      ssm_q   <= 1'b0;
      ssi_q   <= 1'b0;
      rdata   <= '0;
      rx_hold <= '0;
      dr_we   <= 1'b0;
      irq     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (wr && addr == A_STAT) {sod_q, ssm_q, ssi_q} <= wdata[2:0];
      if (rd) begin
        case (addr)
          A_CTRL:  rdata <= ctrl_q;
          A_STAT:  rdata <= {f_flag[F_DONE], f_flag[F_WCOL], f_flag[F_OVR],
                             f_flag[F_MODF], 1'b0, sod_q, ssm_q, ssi_q};
          A_DATA:  rdata <= rx_hold;
          default: rdata <= '0;
        endcase
      end
      if (rx_valid && !f_flag[F_DONE]) rx_hold <= rx_byte;
      dr_we  <= data_wr && !wr_block && !tx_busy;
      irq    <= ctrl_q[C_IE] && (f_flag[F_DONE] || f_flag[F_OVR] || f_flag[F_MODF]);
      sdo_oe <= ctrl_q[C_PE] && !sod_q;
    end
  end

  // R2: a write refused by the pending flag never reaches the engine
  a_r2_block: assert property (@(posedge clk) disable iff (rst)
    (data_wr && f_flag[F_DONE] && !f_mark[F_DONE]) |=> !dr_we);
  // R3: a colliding write is not passed on
  a_r3_collide: assert property (@(posedge clk) disable iff (rst)
    (data_wr && tx_busy) |=> !dr_we && f_flag[F_WCOL]);
  // R4: overrun keeps the older byte
  a_r4_keep: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && f_flag[F_DONE]) |=> $stable(rx_hold) && f_flag[F_OVR]);
  // R6: interrupt follows enable and flags
  a_r6_irq: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == ($past(ctrl_q[C_IE]) &&
      ($past(f_flag[F_DONE]) || $past(f_flag[F_OVR]) || $past(f_flag[F_MODF]))));
  // R8: output enable needs peripheral enable and no disable
  a_r8_oe: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> $past(ctrl_q[C_PE]) && !$past(sod_q));
  // R5: mode fault only in master mode
  a_r5_modf: assert property (@(posedge clk) disable iff (rst)
    $rose(f_flag[F_MODF]) |-> $past(master_mode) && !$past(ss_int));
endmodule

// File: tb/spi_flag_ctrl_test.sv
module spi_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] addr;
  logic       rd, wr;
  logic [7:0] wdata, rdata;
  logic       xfer_done, rx_valid, tx_busy, master_mode, ss_pin;
  logic [7:0] rx_byte, rx_hold;
  logic       irq, ss_int, sdo_oe, dr_we;

  int total = 0;
  int bad = 0;
  int we_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_flag_ctrl uut (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .xfer_done(xfer_done), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_busy(tx_busy), .master_mode(master_mode),
    .ss_pin(ss_pin), .irq(irq), .ss_int(ss_int), .sdo_oe(sdo_oe),
    .rx_hold(rx_hold), .dr_we(dr_we));

  always @(posedge clk) if (!rst && dr_we) we_cnt <= we_cnt + 1;

  // {pe, sod, ssm, ssi, pin, exp_ss, exp_oe}
  localparam logic [6:0] VEC [8] = '{
    7'b1_0_0_0_1_1_1, 7'b1_0_0_0_0_0_1, 7'b1_1_0_0_1_1_0, 7'b0_0_0_0_1_1_0,
    7'b1_0_1_0_1_0_1, 7'b1_0_1_1_0_1_1, 7'b0_1_1_1_1_1_0, 7'b1_0_1_0_0_0_1};

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input logic [1:0] a, input logic r, input logic [7:0] d);
    addr = a; rd = r; wr = !r; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] b);
    xfer_done = 1'b1; rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    xfer_done = 1'b0; rx_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    rst = 1'b1; addr = 0; rd = 0; wr = 0; wdata = 0; xfer_done = 0;
    rx_valid = 0; rx_byte = 0; tx_busy = 0; master_mode = 0; ss_pin = 1;
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({irq, dr_we, sdo_oe, ss_int}, 8'h01, "R11 outputs after reset");
    chk(rx_hold, 8'h00, "R11 rx_hold after reset");
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h00, "R11 status after reset");

    // R8/R9 table walk
    foreach (VEC[i]) begin
      bus(2'd0, 1'b0, {1'b0, VEC[i][6], 6'd0});
      bus(2'd1, 1'b0, {5'd0, VEC[i][5:3]});
      ss_pin = VEC[i][2];
      cyc(4);
      chk({7'd0, ss_int}, {7'd0, VEC[i][1]}, $sformatf("R9 ss_int vec %0d", i));
      chk({7'd0, sdo_oe}, {7'd0, VEC[i][0]}, $sformatf("R8 sdo_oe vec %0d", i));
    end

    // R7 status write touches low bits only
    bus(2'd1, 1'b0, 8'hFF);
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h07, "R7 status write only bits 2..0");
    bus(2'd1, 1'b0, 8'h02); // ssm=1, ssi=0: selected, keeps modf quiet
    ss_pin = 1'b1;
    bus(2'd0, 1'b0, 8'hC0); // ie=1, pe=1

    // R1 transfer complete, R6 irq
    pulse_rx(8'hA5);
    cyc(2);
    chk({7'd0, irq}, 8'h01, "R6 irq on transfer complete");
    chk(rx_hold, 8'hA5, "R4 rx_hold loaded");

    // R2 write refused before status read
    c0 = we_cnt;
    bus(2'd2, 1'b0, 8'h11);
    cyc(2);
    chk(we_cnt[7:0], c0[7:0], "R2 write blocked while flag pending");

    // R1 data access without status read does not clear
    bus(2'd2, 1'b1, 8'h00);
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h82, "R1 flag stays without status read first");

    // R4 overrun keeps old byte
    pulse_rx(8'h3C);
    cyc(1);
    chk(rx_hold, 8'hA5, "R4 overrun discards new byte");
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'hA2, "R4 overrun visible");
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h82, "R4 status read cleared overrun");
    bus(2'd2, 1'b1, 8'h00);
    chk(rdata, 8'hA5, "R1 data read value");
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h02, "R1 cleared by status then data access");
    cyc(1);
    chk({7'd0, irq}, 8'h00, "R6 irq drops with flags");

    // R2 accepted write
    c0 = we_cnt;
    bus(2'd2, 1'b0, 8'h22);
    cyc(1);
    chk(we_cnt[7:0], c0[7:0] + 8'd1, "R2 write accepted when clear");

    // R3 write collision
    tx_busy = 1'b1;
    c0 = we_cnt;
    bus(2'd2, 1'b0, 8'h33);
    tx_busy = 1'b0;
    cyc(1);
    chk(we_cnt[7:0], c0[7:0], "R3 colliding write not passed");
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h42, "R3 collision flag set");
    chk({7'd0, irq}, 8'h00, "R6 collision alone gives no irq");
    bus(2'd2, 1'b1, 8'h00);
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h02, "R3 collision cleared by sequence");

    // R5 mode fault
    bus(2'd1, 1'b0, 8'h00); // pin source
    master_mode = 1'b1;
    ss_pin = 1'b0;
    cyc(5);
    ss_pin = 1'b1;
    cyc(5);
    bus(2'd0, 1'b0, 8'hC0);
    cyc(1);
    chk({7'd0, irq}, 8'h01, "R5 control write alone keeps mode fault");
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h10, "R5 mode fault set");
    bus(2'd0, 1'b0, 8'hC0);
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h00, "R5 cleared by status then control write");
    master_mode = 1'b0;

    // R10 set event beats the clearing access
    pulse_rx(8'h5A);
    bus(2'd1, 1'b1, 8'h00);
    addr = 2'd2; rd = 1'b1; xfer_done = 1'b1;
    @(negedge clk);
    rd = 1'b0; xfer_done = 1'b0;
    bus(2'd2, 1'b1, 8'h00);
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h80, "R10 flag survives same-cycle clear, marker dropped");
    bus(2'd2, 1'b1, 8'h00);
    bus(2'd1, 1'b1, 8'h00);
    chk(rdata, 8'h00, "R10 fresh sequence clears");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule